// File: doc/BRIEF.md
# Parallel Port Slave Receiver

This block sits on the peripheral end of a standard host parallel port and receives traffic in one direction only, from the host to the device. Each transfer carries eight data bits plus a ninth bit whose meaning (parity, data or command) is left to software. When the host pulls its strobe low, the block captures the nine bits and raises busy. Busy holds off the host until software collects the word over an APB register port. Software's read of the data register starts an active-low acknowledge pulse of programmable width, and busy drops when that pulse ends.

The host's device-reset (init) and auto-line-feed lines are watched for their asserting edges. Each of these, the arrival of a word, and an overrun has its own sticky status bit. Three of the sources drive a single interrupt line through separate mask bits. All host lines are taken through two-flop synchronizers before any edge is detected. The default acknowledge width is 415 clocks, which is about 5 us at an 83 MHz APB clock.

Top module: `ppslv_top`

## Requirements
- R1: After reset, busy is 0, the acknowledge line is 1, irq is 0, STATUS (offset 0x4) and MASK (offset 0x8) read 0, and ACKLEN (offset 0xC) reads 415.
- R2: A falling edge on the host strobe latches the eight data bits and the ninth bit. The same edge raises busy and sets STATUS bit 0. All three are visible after the third rising clock edge that follows the strobe's fall.
- R3: DATA (offset 0x0) reads the byte in bits 7:0 and the ninth bit in bit 8. Bits 31:9 read 0.
- R4: Busy stays high until software reads DATA. That read drives the acknowledge line low from the next cycle for ACKLEN cycles, with a value of 0 treated as 1. Busy falls in the same cycle that the acknowledge line returns high.
- R5: The acknowledge line is low only while busy is high.
- R6: A strobe falling edge while busy is high sets STATUS bit 3 (overrun) and leaves the held word unchanged.
- R7: A falling edge on the host init line sets STATUS bit 1, and a falling edge on the host auto-feed line sets STATUS bit 2. Both follow the same three-edge timing as R2.
- R8: Writing STATUS clears every bit written as 1 and leaves the others unchanged. A new event in the same cycle wins over the clear.
- R9: irq is the OR of STATUS bits 2:0 ANDed with MASK bits 2:0 (bit 0 word, bit 1 init, bit 2 auto-feed). The overrun bit never drives irq.
- R10: Reading DATA while busy is low has no effect on busy or on the acknowledge line.
- R11: pready is always high, so every access completes without wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address; bits 3:2 select the register |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pp_strobe_n | input | 1 | Host strobe, active low |
| pp_data | input | 8 | Host data byte |
| pp_ninth | input | 1 | Ninth bit sent with the byte |
| pp_init_n | input | 1 | Host device-reset request, active low |
| pp_autofd_n | input | 1 | Host auto line feed, active low |
| pp_ack_n | output | 1 | Acknowledge to host, active low |
| pp_busy | output | 1 | Busy to host |
| irq | output | 1 | Masked interrupt request |

## Verification
Host-side events take effect at the third rising edge after the input changes: two edges pass through the synchronizer and one through the edge register. APB effects take effect at the edge that ends the access phase: acknowledge starts then, and status and mask updates appear then. The bench's reference model keeps a four-deep history of each host line and applies an event only when the sample from three edges back is high and the one from two edges back is low. It updates at every rising edge, and busy, acknowledge and irq are compared against it at every falling edge. Read data is sampled during the access phase, just after the bench raises penable.

// File: rtl/ppslv_pkg.sv
`timescale 1ns/1ps
package ppslv_pkg;
  localparam int DW = 32;
  localparam int WORD_W = 9;
  localparam int STAT_W = 4;
  localparam int MASK_W = 3;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_HOLD = 2'd1,
    HS_ACK  = 2'd2
  } hs_state_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_MASK = 2'd2;
  localparam logic [1:0] REG_ALEN = 2'd3;
endpackage

// File: rtl/ppslv_edge.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus falling-edge detect for active-low host lines.
module ppslv_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_n,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= line_n[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign fall[i] = prev_q & ~s2_q;
  end
endmodule

// File: rtl/ppslv_hs.sv
`timescale 1ns/1ps
// Host handshake: capture word, hold busy until read, timed acknowledge.
module ppslv_hs
  import ppslv_pkg::*;
#(
  parameter int ACK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_fall,
  input  logic [WORD_W-1:0] word_in,
  input  logic              rd_data,
  input  logic [ACK_W-1:0]  ack_len,
  output logic              busy,
  output logic              ack_n,
  output logic [WORD_W-1:0] word,
  output logic              evt_rx,
  output logic              evt_ovr
);
  hs_state_e         state_q, state_d;
  logic [ACK_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              word_en, cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    word_en = 1'b0;
    cnt_en  = 1'b0;
    evt_rx  = 1'b0;
    evt_ovr = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (strb_fall) begin
          state_d = HS_HOLD;
          word_d  = word_in;
          word_en = 1'b1;
          evt_rx  = 1'b1;
        end
      end
      HS_HOLD: begin
        evt_ovr = strb_fall;
        if (rd_data) begin
          state_d = HS_ACK;
          cnt_d   = (ack_len == '0) ? ACK_W'(1) : ack_len;
          cnt_en  = 1'b1;
        end
      end
      HS_ACK: begin
        evt_ovr = strb_fall;
        cnt_en  = 1'b1;
        if (cnt_q == ACK_W'(1)) state_d = HS_IDLE;
        else                    cnt_d   = cnt_q - ACK_W'(1);
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (word_en) word_q <= word_d;
    end
  end

  assign busy  = (state_q != HS_IDLE);
  assign ack_n = (state_q != HS_ACK);
  assign word  = word_q;
endmodule

// File: rtl/ppslv_regs.sv
`timescale 1ns/1ps
// APB register file: data, sticky status (W1C), mask, acknowledge width.
module ppslv_regs
  import ppslv_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int ACK_W   = 16,
  parameter int ACK_RST = 415
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic [WORD_W-1:0] word,
  input  logic              evt_rx,
  input  logic              evt_ovr,
  input  logic              evt_init,
  input  logic              evt_afd,
  output logic              rd_data,
  output logic [ACK_W-1:0]  ack_len,
  output logic [STAT_W-1:0] status,
  output logic [MASK_W-1:0] mask,
  output logic              irq
);
  logic [1:0]        sel;
  logic              acc, wr_stat, wr_mask, wr_alen;
  logic [STAT_W-1:0] stat_q, stat_d, stat_set;
  logic [MASK_W-1:0] mask_q;
  logic [ACK_W-1:0]  alen_q;
  logic              unused_bits;

  assign sel      = paddr[3:2];
  assign acc      = psel & penable;
  assign wr_stat  = acc & pwrite & (sel == REG_STAT);
  assign wr_mask  = acc & pwrite & (sel == REG_MASK);
  assign wr_alen  = acc & pwrite & (sel == REG_ALEN);
  assign rd_data  = acc & ~pwrite & (sel == REG_DATA);
  assign stat_set = {evt_ovr, evt_afd, evt_init, evt_rx};

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & ~pwdata[STAT_W-1:0];
    stat_d = stat_d | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      alen_q <= ACK_W'(ACK_RST);
    end else begin
      stat_q <= stat_d;
      if (wr_mask) mask_q <= pwdata[MASK_W-1:0];
      if (wr_alen) alen_q <= pwdata[ACK_W-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel)
        REG_DATA: prdata = DW'(word);
        REG_STAT: prdata = DW'(stat_q);
        REG_MASK: prdata = DW'(mask_q);
        default:  prdata = DW'(alen_q);
      endcase
    end
  end

  assign irq         = |(stat_q[MASK_W-1:0] & mask_q);
  assign ack_len     = alen_q;
  assign status      = stat_q;
  assign mask        = mask_q;
  assign unused_bits = ^{pwdata, paddr};
endmodule

// File: rtl/ppslv_top.sv
`timescale 1ns/1ps
module ppslv_top
  import ppslv_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int ACK_W   = 16,
  parameter int ACK_RST = 415
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              pp_strobe_n,
  input  logic [7:0]        pp_data,
  input  logic              pp_ninth,
  input  logic              pp_init_n,
  input  logic              pp_autofd_n,
  output logic              pp_ack_n,
  output logic              pp_busy,
  output logic              irq
);
  localparam int NLINES = 3;

  logic [1:0]        rsync_q;
  logic              rst_int;
  logic [NLINES-1:0] falls;
  logic              rd_data, evt_rx, evt_ovr;
  logic [WORD_W-1:0] hs_word;
  logic [ACK_W-1:0]  alen;
  logic [STAT_W-1:0] stat_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rsync_q <= 2'b00;
    else          rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int = rsync_q[1];

  ppslv_edge #(.N(NLINES)) u_edge (
    .clk    (pclk),
    .rst_n  (rst_int),
    .line_n ({pp_autofd_n, pp_init_n, pp_strobe_n}),
    .fall   (falls)
  );

  ppslv_hs #(.ACK_W(ACK_W)) u_hs (
    .clk       (pclk),
    .rst_n     (rst_int),
    .strb_fall (falls[0]),
    .word_in   ({pp_ninth, pp_data}),
    .rd_data   (rd_data),
    .ack_len   (alen),
    .busy      (pp_busy),
    .ack_n     (pp_ack_n),
    .word      (hs_word),
    .evt_rx    (evt_rx),
    .evt_ovr   (evt_ovr)
  );

  ppslv_regs #(.ADDR_W(ADDR_W), .ACK_W(ACK_W), .ACK_RST(ACK_RST)) u_regs (
    .clk      (pclk),
    .rst_n    (rst_int),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .word     (hs_word),
    .evt_rx   (evt_rx),
    .evt_ovr  (evt_ovr),
    .evt_init (falls[1]),
    .evt_afd  (falls[2]),
    .rd_data  (rd_data),
    .ack_len  (alen),
    .status   (stat_q),
    .mask     (mask_q),
    .irq      (irq)
  );

  assign pready = 1'b1;
endmodule

// File: rtl/ppslv_chk.sv
`timescale 1ns/1ps
module ppslv_chk #(
  parameter int ADDR_W = 4,
  parameter int ACK_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              busy,
  input logic              ack_n,
  input logic [8:0]        word,
  input logic [ACK_W-1:0]  ack_len,
  input logic [3:0]        status,
  input logic              irq
);
  logic             rd0;
  logic [ACK_W-1:0] low_cnt;
  logic [ACK_W-1:0] want_len;

  assign rd0      = psel && penable && !pwrite && (paddr[3:2] == 2'd0);
  assign want_len = (ack_len == '0) ? ACK_W'(1) : ack_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= '0;
    else if (ack_n) low_cnt <= '0;
    else            low_cnt <= low_cnt + ACK_W'(1);
  end

  AST_ACK_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !ack_n |-> busy); // R5
  AST_BUSY_WAITS_READ: assert property (@(posedge clk) disable iff (!rst_n) (busy && ack_n && !rd0) |=> busy); // R4
  AST_READ_STARTS_ACK: assert property (@(posedge clk) disable iff (!rst_n) (busy && ack_n && rd0) |=> !ack_n); // R4
  AST_ACK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(ack_n) |-> (low_cnt == want_len)); // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(word)); // R6
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (|status[2:0])); // R9
endmodule

bind ppslv_top ppslv_chk #(.ADDR_W(ADDR_W), .ACK_W(ACK_W)) u_chk (
  .clk     (pclk),
  .rst_n   (rst_int),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .busy    (pp_busy),
  .ack_n   (pp_ack_n),
  .word    (hs_word),
  .ack_len (alen),
  .status  (stat_q),
  .irq     (irq)
);

// File: tb/ppslv_top_tb_top.sv
`timescale 1ns/1ps
module ppslv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [3:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready;
  logic        stb_n, ninth, init_n, afd_n;
  logic [7:0]  data;
  logic        ack_n, busy, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ppslv_top dut_i (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pp_strobe_n(stb_n), .pp_data(data), .pp_ninth(ninth), .pp_init_n(init_n),
    .pp_autofd_n(afd_n), .pp_ack_n(ack_n), .pp_busy(busy), .irq(irq)
  );

  // Behavioural reference model
  bit q_s[$], q_i[$], q_a[$];
  int m_st, m_cnt, m_alen;
  bit [8:0] m_word;
  bit [3:0] m_stat;
  bit [2:0] m_mask;

  task automatic model_reset();
    q_s = '{1, 1, 1, 1}; q_i = '{1, 1, 1, 1}; q_a = '{1, 1, 1, 1};
    m_st = 0; m_cnt = 0; m_alen = 415; m_word = '0; m_stat = '0; m_mask = '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit fs, fi, fa, rx, ov, acc;
      q_s.push_front(stb_n);  void'(q_s.pop_back());
      q_i.push_front(init_n); void'(q_i.pop_back());
      q_a.push_front(afd_n);  void'(q_a.pop_back());
      fs = q_s[3] && !q_s[2];
      fi = q_i[3] && !q_i[2];
      fa = q_a[3] && !q_a[2];
      acc = psel && penable;
      rx = 0; ov = 0;
      if (m_st == 0) begin
        if (fs) begin m_st = 1; m_word = {ninth, data}; rx = 1; end
      end else if (m_st == 1) begin
        ov = fs;
        if (acc && !pwrite && paddr[3:2] == 0) begin
          m_st = 2; m_cnt = (m_alen == 0) ? 1 : m_alen;
        end
      end else begin
        ov = fs;
        if (m_cnt == 1) m_st = 0; else m_cnt--;
      end
      if (acc && pwrite && paddr[3:2] == 1) m_stat &= ~pwdata[3:0];
      m_stat |= {ov, fa, fi, rx};
      if (acc && pwrite && paddr[3:2] == 2) m_mask = pwdata[2:0];
      if (acc && pwrite && paddr[3:2] == 3) m_alen = pwdata[15:0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 busy", 32'(busy), 32'(m_st != 0));
      chk("R4 ack", 32'(ack_n), 32'(m_st != 2));
      chk("R9 irq", 32'(irq), 32'(|(m_stat[2:0] & m_mask)));
      if (!ack_n) chk("R5 ack only while busy", 32'(busy), 32'd1);
    end
  end

  task automatic apb_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [3:0] a, logic [31:0] exp, string req);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1;
    chk(req, prdata, exp);
    chk("R11 pready", 32'(pready), 32'd1);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic host_send(logic [7:0] b, logic n9);
    @(negedge clk); data = b; ninth = n9; stb_n = 0;
    repeat (4) @(negedge clk);
    stb_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_line(bit which);
    @(negedge clk);
    if (which) afd_n = 0; else init_n = 0;
    repeat (4) @(negedge clk);
    afd_n = 1; init_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_and_time(logic [31:0] exp_word, int exp_len, string req);
    int lows = 0;
    apb_rd(4'h0, exp_word, req);
    for (int k = 0; k < 2000 && (busy || !ack_n); k++) begin
      if (!ack_n) lows++;
      @(negedge clk);
    end
    chk("R4 ack width", 32'(lows), 32'(exp_len));
    chk("R4 busy dropped", 32'(busy), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    stb_n = 1; init_n = 1; afd_n = 1; data = 0; ninth = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 ack", 32'(ack_n), 32'd1);
    chk("R1 irq", 32'(irq), 32'd0);
    apb_rd(4'h4, 32'd0, "R1 status");
    apb_rd(4'h8, 32'd0, "R1 mask");
    apb_rd(4'hC, 32'd415, "R1 acklen");
    // R10 read while idle
    apb_rd(4'h0, 32'd0, "R10 idle read");
    repeat (3) @(negedge clk);
    chk("R10 no ack", 32'(ack_n), 32'd1);
    chk("R10 no busy", 32'(busy), 32'd0);
    // R2/R3 capture, R4 acknowledge
    apb_wr(4'hC, 32'd6);
    @(negedge clk); data = 8'hA5; ninth = 1; stb_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 busy not yet", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R2 busy after third edge", 32'(busy), 32'd1);
    stb_n = 1;
    repeat (4) @(negedge clk);
    apb_rd(4'h4, 32'h1, "R2 status rx");
    read_and_time(32'h1A5, 6, "R3 data layout");
    // R8 W1C
    apb_wr(4'h4, 32'h2);
    apb_rd(4'h4, 32'h1, "R8 clear of unset bit");
    apb_wr(4'h4, 32'h1);
    apb_rd(4'h4, 32'h0, "R8 cleared");
    // R6 overrun
    host_send(8'h3C, 0);
    host_send(8'h77, 1);
    apb_rd(4'h4, 32'h9, "R6 overrun flag");
    read_and_time(32'h03C, 6, "R6 word kept");
    apb_wr(4'h4, 32'hF);
    // R7 / R9
    pulse_line(0);
    apb_rd(4'h4, 32'h2, "R7 init flag");
    chk("R9 masked", 32'(irq), 32'd0);
    apb_wr(4'h8, 32'h2);
    @(negedge clk);
    chk("R9 init enabled", 32'(irq), 32'd1);
    pulse_line(1);
    apb_rd(4'h4, 32'h6, "R7 autofeed flag");
    apb_wr(4'h4, 32'h2);
    @(negedge clk);
    chk("R9 autofeed masked", 32'(irq), 32'd0);
    apb_wr(4'h8, 32'h4);
    @(negedge clk);
    chk("R9 autofeed enabled", 32'(irq), 32'd1);
    apb_wr(4'h4, 32'hF);
    apb_wr(4'h8, 32'h7);
    host_send(8'h11, 0);
    host_send(8'h22, 0);
    apb_wr(4'h4, 32'h1);
    apb_rd(4'h4, 32'h8, "R9 overrun only");
    chk("R9 overrun no irq", 32'(irq), 32'd0);
    read_and_time(32'h011, 6, "R3 second word");
    apb_wr(4'h4, 32'hF);
    // R4 default width
    apb_wr(4'hC, 32'd415);
    host_send(8'h5A, 0);
    chk("R4 held before read", 32'(busy), 32'd1);
    read_and_time(32'h05A, 415, "R4 default width word");
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule